// File: doc/BRIEF.md
# Byte-Wide Host Slave Word Assembler

This block is the write side of a slave host port with an 8-bit data bus. An external host delivers each 24-bit word as three separate byte writes. The block collects those bytes, least significant byte first, and offers each finished word to the internal logic through a valid/ready handshake. The host pins are asynchronous to the internal clock. Every strobe, the direction line, the chip select and the data byte pass through a two-stage synchronizer. Transfers are then found by the falling edges of the synchronized strobes, so the internal clock has to run at least three times faster than the host transfer rate.

A static input selects one of two pin configurations. With a pair of strobes, a low-going write strobe marks a write and a low-going read strobe marks a read. With a single strobe, a low-going data strobe marks a transfer, and the active-low read/write line, sampled with it, gives the direction. Reads do not advance the byte framing. A word that completes while the previous word is still waiting is dropped and raises a sticky overflow flag. The internal side can pulse a realign input to restart framing at the first byte of a word.

Top module: `hbw_host_slave`

## Requirements
- R1: While reset is high and in the cycle after it is released, `word_valid` and `overflow` are 0.
- R2: In paired-strobe mode (`single_strobe_mode`=0), three write-strobe transfers made with `cs_n` low produce one word on `word_data` with `word_valid`=1. The first byte goes in bits 7:0, the second in bits 15:8 and the third in bits 23:16.
- R3: In single-strobe mode (`single_strobe_mode`=1), a falling edge of `ds_n` while `rw_n`=0 and `cs_n`=0 is a byte write, and three such writes form a word with the same byte order as R2.
- R4: Read transfers do not advance the byte framing. In paired-strobe mode a read is a falling edge of `rd_n`. In single-strobe mode a read is a falling edge of `ds_n` with `rw_n`=1.
- R5: Strobe edges that occur while `cs_n` is high are ignored.
- R6: Once `word_valid` is 1 it stays 1, with `word_data` unchanged, until a cycle in which `word_ready` is 1. After that cycle `word_valid` returns to 0 unless a new word completes in the same cycle.
- R7: If a third byte arrives while `word_valid`=1 and `word_ready`=0, the new word is discarded, `word_data` keeps the pending word, and `overflow` becomes 1.
- R8: `overflow` stays 1 until reset, even after later words are accepted normally.
- R9: A one-cycle pulse on `frame_clr` throws away any partly received word, and the next byte written becomes bits 7:0 of a new word.
- R10: The pin that the unselected mode uses has no effect: `ds_n` in paired-strobe mode, and `wr_n` in single-strobe mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| single_strobe_mode | input | 1 | Static pin configuration: 0 = paired strobes, 1 = single strobe with direction line |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| wr_n | input | 1 | Host write strobe (paired-strobe mode), active low |
| rd_n | input | 1 | Host read strobe (paired-strobe mode), active low |
| ds_n | input | 1 | Host data strobe (single-strobe mode), active low |
| rw_n | input | 1 | Host direction (single-strobe mode): 0 = write, 1 = read |
| host_data | input | 8 | Host write data byte |
| frame_clr | input | 1 | Internal pulse that restarts byte framing |
| word_data | output | 24 | Assembled word |
| word_valid | output | 1 | Assembled word is available |
| word_ready | input | 1 | Internal side takes the word |
| overflow | output | 1 | Sticky flag: a completed word was dropped |

## Verification
The hardest state to reach from the ports is a word completing while the previous one is still held. Reaching it takes a full second frame of three synchronized host writes with `word_ready` kept low the whole time, and the result must show the old data unchanged. The bench drives exactly that sequence. It then releases `word_ready` and sends another word, which shows that the flag stays set while normal delivery resumes. Read strobes and the unused mode's pin are placed between genuine writes, so any miscount shows up as a word that completes too early or carries the wrong bytes.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

    localparam int HBW_BYTE_W = 8;
    localparam int HBW_BYTES  = 3;

    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic rd_n;
        logic ds_n;
        logic rw_n;
    } hbw_pins_t;

    localparam int HBW_PINS_W = $bits(hbw_pins_t);

    typedef enum logic {
        HBW_PAIRED = 1'b0,
        HBW_SINGLE = 1'b1
    } hbw_mode_e;

    function automatic logic hbw_fell(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

endpackage

// File: rtl/hbw_sync.sv
module hbw_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[s] <= RST_VAL;
            end else begin
                if (s == 0) stage_q[s] <= d;
                else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hbw_strobe_decode.sv
module hbw_strobe_decode
    import hbw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  hbw_mode_e mode,
    input  hbw_pins_t pins_s,
    output logic      wr_evt
);
    hbw_pins_t pins_prev;
    logic      wr_edge, rd_edge;

    always_ff @(posedge clk) begin
        if (rst) pins_prev <= '1;
        else     pins_prev <= pins_s;
    end

    always_comb begin
        wr_edge = 1'b0;
        rd_edge = 1'b0;
        if (!pins_s.cs_n) begin
            if (mode == HBW_SINGLE) begin
                wr_edge = hbw_fell(pins_prev.ds_n, pins_s.ds_n) & ~pins_s.rw_n;
                rd_edge = hbw_fell(pins_prev.ds_n, pins_s.ds_n) &  pins_s.rw_n;
            end else begin
                wr_edge = hbw_fell(pins_prev.wr_n, pins_s.wr_n);
                rd_edge = hbw_fell(pins_prev.rd_n, pins_s.rd_n);
            end
        end
    end

    // a simultaneous read edge marks a bus conflict: the write is suppressed
    assign wr_evt = wr_edge & ~rd_edge;

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        wr_evt |=> !wr_evt);
endmodule

// File: rtl/hbw_assembler.sv
module hbw_assembler #(
    parameter int BYTE_W = 8,
    parameter int BYTES  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_evt,
    input  logic [BYTE_W-1:0]       byte_in,
    input  logic                    frame_clr,
    output logic [BYTE_W*BYTES-1:0] word_data,
    output logic                    word_valid,
    input  logic                    word_ready,
    output logic                    overflow
);
    localparam int WORD_W = BYTE_W * BYTES;
    localparam int CNT_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTES - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] merged;
    logic              last_byte;
    logic              slot_free;

    assign last_byte = (cnt_q == LAST_IDX);
    assign slot_free = !word_valid || word_ready;

    always_comb begin
        merged = acc_q;
        merged[(BYTES-1)*BYTE_W +: BYTE_W] = byte_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            acc_q      <= '0;
            word_data  <= '0;
            word_valid <= 1'b0;
            overflow   <= 1'b0;
        end else begin
            if (word_valid && word_ready) word_valid <= 1'b0;
            if (frame_clr) begin
                cnt_q <= '0;
            end else if (wr_evt) begin
                if (last_byte) begin
                    cnt_q <= '0;
                    if (slot_free) begin
                        word_data  <= merged;
                        word_valid <= 1'b1;
                    end else begin
                        overflow <= 1'b1;
                    end
                end else begin
                    acc_q[cnt_q*BYTE_W +: BYTE_W] <= byte_in;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        word_valid && !word_ready |=> word_valid && $stable(word_data));
    assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(word_valid && !word_ready && wr_evt));
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    assert_realign_R9: assert property (@(posedge clk) disable iff (rst)
        frame_clr |=> cnt_q == '0);
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_IDX);
endmodule

// File: rtl/hbw_host_slave.sv
module hbw_host_slave
    import hbw_pkg::*;
#(
    parameter int BYTE_W      = HBW_BYTE_W,
    parameter int BYTES       = HBW_BYTES,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    single_strobe_mode,
    input  logic                    cs_n,
    input  logic                    wr_n,
    input  logic                    rd_n,
    input  logic                    ds_n,
    input  logic                    rw_n,
    input  logic [BYTE_W-1:0]       host_data,
    input  logic                    frame_clr,
    output logic [BYTE_W*BYTES-1:0] word_data,
    output logic                    word_valid,
    input  logic                    word_ready,
    output logic                    overflow
);
    localparam int SYNC_W = HBW_PINS_W + BYTE_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {{HBW_PINS_W{1'b1}}, {BYTE_W{1'b0}}};

    hbw_pins_t          pins_raw, pins_s;
    logic [BYTE_W-1:0]  data_s;
    logic               wr_evt;
    hbw_mode_e          mode;

    assign pins_raw = '{cs_n: cs_n, wr_n: wr_n, rd_n: rd_n, ds_n: ds_n, rw_n: rw_n};
    assign mode     = single_strobe_mode ? HBW_SINGLE : HBW_PAIRED;

    hbw_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pins_raw, host_data}),
        .q   ({pins_s, data_s})
    );

    hbw_strobe_decode u_decode (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .pins_s (pins_s),
        .wr_evt (wr_evt)
    );

    hbw_assembler #(
        .BYTE_W (BYTE_W),
        .BYTES  (BYTES)
    ) u_asm (
        .clk        (clk),
        .rst        (rst),
        .wr_evt     (wr_evt),
        .byte_in    (data_s),
        .frame_clr  (frame_clr),
        .word_data  (word_data),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .overflow   (overflow)
    );

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> !word_valid && !overflow);
endmodule

// File: tb/tb_hbw_host_slave.sv
module tb_hbw_host_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        single_strobe_mode = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, ds_n = 1'b1, rw_n = 1'b1;
    logic [7:0]  host_data = '0;
    logic        frame_clr = 1'b0;
    logic [23:0] word_data;
    logic        word_valid;
    logic        word_ready = 1'b0;
    logic        overflow;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    hbw_host_slave dut (
        .clk (clk), .rst (rst), .single_strobe_mode (single_strobe_mode),
        .cs_n (cs_n), .wr_n (wr_n), .rd_n (rd_n), .ds_n (ds_n), .rw_n (rw_n),
        .host_data (host_data), .frame_clr (frame_clr),
        .word_data (word_data), .word_valid (word_valid),
        .word_ready (word_ready), .overflow (overflow)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic single);
        @(negedge clk);
        rst = 1'b1;
        single_strobe_mode = single;
        word_ready = 1'b0;
        frame_clr = 1'b0;
        cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; ds_n = 1'b1; rw_n = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(2);
    endtask

    // kind: 0 = write strobe, 1 = read strobe, 2 = data strobe
    task automatic pulse(input int kind, input logic dir_n, input logic sel_n, input logic [7:0] b);
        @(negedge clk);
        host_data = b;
        cs_n = sel_n;
        rw_n = dir_n;
        idle(1);
        case (kind)
            0: wr_n = 1'b0;
            1: rd_n = 1'b0;
            default: ds_n = 1'b0;
        endcase
        idle(4);
        wr_n = 1'b1; rd_n = 1'b1; ds_n = 1'b1;
        idle(1);
        cs_n = 1'b1; rw_n = 1'b1;
        idle(4);
    endtask

    task automatic host_write(input logic [7:0] b);
        if (single_strobe_mode) pulse(2, 1'b0, 1'b0, b);
        else                    pulse(0, 1'b1, 1'b0, b);
    endtask

    task automatic host_word(input logic [23:0] w);
        host_write(w[7:0]);
        host_write(w[15:8]);
        host_write(w[23:16]);
    endtask

    task automatic accept();
        @(negedge clk);
        word_ready = 1'b1;
        @(negedge clk);
        word_ready = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        check("R1 valid after reset", {31'b0, word_valid}, 32'd0);
        check("R1 overflow after reset", {31'b0, overflow}, 32'd0);
    endtask

    task automatic t_paired_word();
        do_reset(1'b0);
        host_write(8'h11);
        host_write(8'h22);
        check("R2 no word after two bytes", {31'b0, word_valid}, 32'd0);
        host_write(8'h33);
        check("R2 valid", {31'b0, word_valid}, 32'd1);
        check("R2 data lsb first", {8'b0, word_data}, 32'h00332211);
        idle(6);
        check("R6 valid held", {31'b0, word_valid}, 32'd1);
        check("R6 data held", {8'b0, word_data}, 32'h00332211);
        accept();
        check("R6 valid cleared", {31'b0, word_valid}, 32'd0);
        host_word(24'hA5C3F0);
        check("R2 second word", {8'b0, word_data}, 32'h00A5C3F0);
    endtask

    task automatic t_single_word();
        do_reset(1'b1);
        host_word(24'h123456);
        check("R3 valid", {31'b0, word_valid}, 32'd1);
        check("R3 data", {8'b0, word_data}, 32'h00123456);
    endtask

    task automatic t_reads_ignored();
        do_reset(1'b0);
        host_write(8'h01);
        pulse(1, 1'b1, 1'b0, 8'hEE);
        host_write(8'h02);
        pulse(1, 1'b1, 1'b0, 8'hDD);
        check("R4 paired read not counted", {31'b0, word_valid}, 32'd0);
        host_write(8'h03);
        check("R4 paired word", {8'b0, word_data}, 32'h00030201);
        do_reset(1'b1);
        host_write(8'h0A);
        pulse(2, 1'b1, 1'b0, 8'hEE);
        host_write(8'h0B);
        pulse(2, 1'b1, 1'b0, 8'hDD);
        check("R4 single read not counted", {31'b0, word_valid}, 32'd0);
        host_write(8'h0C);
        check("R4 single word", {8'b0, word_data}, 32'h000C0B0A);
    endtask

    task automatic t_cs_gate();
        do_reset(1'b0);
        host_write(8'h44);
        pulse(0, 1'b1, 1'b1, 8'h99);
        host_write(8'h55);
        pulse(0, 1'b1, 1'b1, 8'h98);
        check("R5 deselected write ignored", {31'b0, word_valid}, 32'd0);
        host_write(8'h66);
        check("R5 word", {8'b0, word_data}, 32'h00665544);
    endtask

    task automatic t_other_pin();
        do_reset(1'b0);
        host_write(8'h21);
        pulse(2, 1'b0, 1'b0, 8'h77);
        host_write(8'h43);
        pulse(2, 1'b0, 1'b0, 8'h78);
        check("R10 ds_n ignored in paired", {31'b0, word_valid}, 32'd0);
        host_write(8'h65);
        check("R10 paired word", {8'b0, word_data}, 32'h00654321);
        do_reset(1'b1);
        host_write(8'h87);
        pulse(0, 1'b0, 1'b0, 8'h77);
        host_write(8'hA9);
        pulse(0, 1'b0, 1'b0, 8'h78);
        check("R10 wr_n ignored in single", {31'b0, word_valid}, 32'd0);
        host_write(8'hCB);
        check("R10 single word", {8'b0, word_data}, 32'h00CBA987);
    endtask

    task automatic t_overflow();
        do_reset(1'b0);
        host_word(24'h0F0E0D);
        check("R7 no overflow yet", {31'b0, overflow}, 32'd0);
        host_word(24'hBADBAD);
        check("R7 overflow set", {31'b0, overflow}, 32'd1);
        check("R7 old word kept", {8'b0, word_data}, 32'h000F0E0D);
        check("R7 still valid", {31'b0, word_valid}, 32'd1);
        accept();
        check("R7 dropped word not delivered", {31'b0, word_valid}, 32'd0);
        host_word(24'h314159);
        check("R8 new word after overflow", {8'b0, word_data}, 32'h00314159);
        accept();
        idle(5);
        check("R8 overflow sticky", {31'b0, overflow}, 32'd1);
        do_reset(1'b0);
        check("R8 overflow cleared by reset", {31'b0, overflow}, 32'd0);
    endtask

    task automatic t_realign();
        do_reset(1'b0);
        host_write(8'hDE);
        host_write(8'hAD);
        @(negedge clk);
        frame_clr = 1'b1;
        @(negedge clk);
        frame_clr = 1'b0;
        host_write(8'h01);
        host_write(8'h02);
        check("R9 no early word", {31'b0, word_valid}, 32'd0);
        host_write(8'h03);
        check("R9 realigned word", {8'b0, word_data}, 32'h00030201);
    endtask

    initial begin
        t_reset();
        t_paired_word();
        t_single_word();
        t_reads_ignored();
        t_cs_gate();
        t_other_pin();
        t_overflow();
        t_realign();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule